// File: doc/BRIEF.md
# Unprivileged Load/Store Address Generator

This block sits in the execute stage of a load/store pipe. It takes one decoded unprivileged byte, halfword or word load or store per cycle and works out two values: the address the memory port presents, and the value written back to the base register. There are three addressing forms:

- **Pre-immediate:** the base plus a small unsigned immediate.
- **Post-immediate:** the bus sees the raw base, and base ± immediate goes back to the register file.
- **Post-register:** as post-immediate, but the offset is another register, optionally shifted or rotated first.

The block also produces three controls for the memory side: the access size, the sign-extend control for the load path, and an attribute that marks the access as user-level whatever mode the core runs in. It rejects encodings that are out of range or forbidden, and blocks writeback for them. All results appear one cycle after the request, together with a valid strobe.

Top module: `unpriv_agu`

## Requirements
- R1: Every output is registered. A request sampled with `in_valid` high at a rising edge shows up after that edge with `out_valid` high. `out_valid` is low after any edge at which `in_valid` was low.
- R2: `user_acc` is high on every valid result, whatever kind of access it is, so privileged code gets user-level permission checks.
- R3: Pre-immediate form (`form`=0): `addr` = `base` + `imm`, and `wb_data` carries that same sum. `up` is ignored and `wb_en` stays low.
- R4: Post forms (`form`=1 immediate, `form`=2 register): `addr` = `base` unchanged, and `wb_data` = `base` + offset when `up`=1, or `base` − offset when `up`=0. `wb_en` is high when the encoding is legal.
- R5: Immediate limits. The pre-immediate form allows `imm` of 0 to 255. The post-immediate form allows 0 to 4095 for word and unsigned byte, and 0 to 255 for any other type. A larger value sets `illegal`.
- R6: The register offset is shaped by `shift_kind`: 0 = shift left, 1 = logical shift right, 2 = arithmetic shift right, 3 = rotate right, 4 = rotate right one place through carry. A right shift by 32 gives zero for the logical kind and all sign bits for the arithmetic kind. Kind 4 puts `carry_in` into bit 31. Kind 4 ignores `shift_amt`.
- R7: Legal amounts are 0–31 for shift left, 1–32 for either right shift, and 1–31 for rotate right. Any other amount, and any kind above 4, sets `illegal`.
- R8: A shifted register offset (anything except shift left by 0) is legal only for word (`acc`=0) and unsigned byte (`acc`=1).
- R9: Register offset form with `rm_idx` = 15 sets `illegal`.
- R10: `acc` encodes 0 word, 1 unsigned byte, 2 signed byte, 3 unsigned halfword, 4 signed halfword. `size` comes out as 0 for byte, 1 for halfword and 2 for word. `sext` is high only for loads of the two signed types.
- R11: A store of a signed type, an `acc` above 4 and a `form` of 3 each set `illegal`.
- R12: Whenever `illegal` is high, `wb_en` is low. Address and writeback values are still computed.
- R13: During reset, `out_valid`, `addr`, `wb_data`, `wb_en`, `size`, `sext`, `user_acc` and `illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| form | input | 2 | 0 pre-immediate, 1 post-immediate, 2 post-register |
| acc | input | 3 | Access type (see R10) |
| is_load | input | 1 | 1 load, 0 store |
| up | input | 1 | 1 add offset, 0 subtract (post forms) |
| base | input | 32 | Base register value |
| rm_val | input | 32 | Offset register value |
| rm_idx | input | 4 | Offset register index |
| imm | input | 12 | Unsigned immediate magnitude |
| shift_kind | input | 3 | Offset shift kind (see R6) |
| shift_amt | input | 6 | Offset shift amount |
| carry_in | input | 1 | Carry flag for rotate-through-carry |
| out_valid | output | 1 | Result valid |
| addr | output | 32 | Bus address |
| wb_data | output | 32 | Updated base value |
| wb_en | output | 1 | Base writeback enable |
| size | output | 2 | 0 byte, 1 halfword, 2 word |
| sext | output | 1 | Sign-extend loaded data |
| user_acc | output | 1 | Access carries user-level permissions |
| illegal | output | 1 | Encoding rejected |

## Verification
The main function is tried with three kinds of pattern:

- **Each addressing form on one fixed base.** This separates pre-indexed from post-indexed handling of `addr`, and shows that only the post forms honour `up` and enable writeback.
- **Register offsets through every shift kind at the edges of its legal range.** Amounts of 0, 31 and 32, a sign-bit operand and carry injection tell a correct shifter and range check apart from an off-by-one or wrong-fill version.
- **Each access type against its legal immediate and shift limits.** Loads and stores are both used, which distinguishes the size decode, the sign-extend control and the illegal cases (register 15, signed stores, shifted halfword offsets). The bench also confirms that writeback is suppressed for them.

// File: rtl/unpriv_agu_pkg.sv
package unpriv_agu_pkg;
  localparam logic [1:0] FORM_PREIMM  = 2'd0;
  localparam logic [1:0] FORM_POSTIMM = 2'd1;
  localparam logic [1:0] FORM_POSTREG = 2'd2;

  localparam logic [2:0] SH_LSL = 3'd0;
  localparam logic [2:0] SH_LSR = 3'd1;
  localparam logic [2:0] SH_ASR = 3'd2;
  localparam logic [2:0] SH_ROR = 3'd3;
  localparam logic [2:0] SH_RRX = 3'd4;

  localparam logic [2:0] ACC_WORD  = 3'd0;
  localparam logic [2:0] ACC_UBYTE = 3'd1;
  localparam logic [2:0] ACC_SBYTE = 3'd2;
  localparam logic [2:0] ACC_UHALF = 3'd3;
  localparam logic [2:0] ACC_SHALF = 3'd4;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/unpriv_agu_shift.sv
module unpriv_agu_shift
  import unpriv_agu_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SHW = $clog2(DW) + 1
) (
  input  logic [DW-1:0]  opnd,
  input  logic [2:0]     kind,
  input  logic [SHW-1:0] amt,
  input  logic           cin,
  output logic [DW-1:0]  res
);
  localparam int RW = $clog2(DW);

  logic [2*DW-1:0] dbl;
  logic [2*DW-1:0] rot;

  always_comb begin
    dbl = {opnd, opnd};
    rot = dbl >> amt[RW-1:0];
    case (kind)
      SH_LSL:  res = opnd << amt;
      SH_LSR:  res = opnd >> amt;
      SH_ASR:  res = DW'($signed(opnd) >>> amt);
      SH_ROR:  res = rot[DW-1:0];
      SH_RRX:  res = {cin, opnd[DW-1:1]};
      default: res = opnd;
    endcase
  end
endmodule

// File: rtl/unpriv_agu_legal.sv
module unpriv_agu_legal
  import unpriv_agu_pkg::*;
#(
  parameter int DW         = 32,
  parameter int IMM_W      = 12,
  parameter int NARROW_MAX = 255,
  parameter int SHW        = $clog2(DW) + 1
) (
  input  logic [1:0]       form,
  input  logic [2:0]       acc,
  input  logic             is_load,
  input  logic [3:0]       rm_idx,
  input  logic [IMM_W-1:0] imm,
  input  logic [2:0]       kind,
  input  logic [SHW-1:0]   amt,
  output logic             bad
);
  localparam logic [IMM_W-1:0] NLIM   = IMM_W'(NARROW_MAX);
  localparam logic [SHW-1:0]   LIM_HI = SHW'(DW);
  localparam logic [SHW-1:0]   LIM_LO = SHW'(DW - 1);

  logic wide_acc;
  logic signed_acc;
  logic shifted;
  logic amt_bad;

  always_comb begin
    wide_acc   = (acc == ACC_WORD) || (acc == ACC_UBYTE);
    signed_acc = (acc == ACC_SBYTE) || (acc == ACC_SHALF);
    shifted    = !((kind == SH_LSL) && (amt == '0));
    case (kind)
      SH_LSL:         amt_bad = amt > LIM_LO;
      SH_LSR, SH_ASR: amt_bad = (amt == '0) || (amt > LIM_HI);
      SH_ROR:         amt_bad = (amt == '0) || (amt > LIM_LO);
      SH_RRX:         amt_bad = 1'b0;
      default:        amt_bad = 1'b1;
    endcase

    bad = (acc > ACC_SHALF) || (signed_acc && !is_load);
    case (form)
      FORM_PREIMM:  bad = bad || (imm > NLIM);
      FORM_POSTIMM: bad = bad || (!wide_acc && (imm > NLIM));
      FORM_POSTREG: bad = bad || (rm_idx == 4'd15) || amt_bad
                          || (shifted && !wide_acc);
      default:      bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/unpriv_agu.sv
module unpriv_agu
  import unpriv_agu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IMM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       form,
  input  logic [2:0]       acc,
  input  logic             is_load,
  input  logic             up,
  input  logic [DW-1:0]    base,
  input  logic [DW-1:0]    rm_val,
  input  logic [3:0]       rm_idx,
  input  logic [IMM_W-1:0] imm,
  input  logic [2:0]       shift_kind,
  input  logic [5:0]       shift_amt,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [DW-1:0]    addr,
  output logic [DW-1:0]    wb_data,
  output logic             wb_en,
  output logic [1:0]       size,
  output logic             sext,
  output logic             user_acc,
  output logic             illegal
);
  localparam int SHW = 6;

  logic [DW-1:0] shifted_rm;
  logic          bad;
  logic [DW-1:0] off;
  logic [DW-1:0] sum;
  logic [DW-1:0] addr_n;
  logic          wbe_n;
  logic [1:0]    size_n;
  logic          sext_n;

  unpriv_agu_shift #(.DW(DW), .SHW(SHW)) u_shift (
    .opnd (rm_val),
    .kind (shift_kind),
    .amt  (shift_amt),
    .cin  (carry_in),
    .res  (shifted_rm)
  );

  unpriv_agu_legal #(.DW(DW), .IMM_W(IMM_W), .NARROW_MAX(255), .SHW(SHW)) u_legal (
    .form    (form),
    .acc     (acc),
    .is_load (is_load),
    .rm_idx  (rm_idx),
    .imm     (imm),
    .kind    (shift_kind),
    .amt     (shift_amt),
    .bad     (bad)
  );

  // next-state logic
  always_comb begin
    off = (form == FORM_POSTREG) ? shifted_rm : {{(DW-IMM_W){1'b0}}, imm};
    sum = ((form == FORM_PREIMM) || up) ? (base + off) : (base - off);
    addr_n = (form == FORM_PREIMM) ? sum : base;
    wbe_n  = ((form == FORM_POSTIMM) || (form == FORM_POSTREG)) && !bad;
    case (acc)
      ACC_UBYTE, ACC_SBYTE: size_n = SZ_BYTE;
      ACC_UHALF, ACC_SHALF: size_n = SZ_HALF;
      default:              size_n = SZ_WORD;
    endcase
    sext_n = is_load && ((acc == ACC_SBYTE) || (acc == ACC_SHALF));
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      addr      <= '0;
      wb_data   <= '0;
      wb_en     <= 1'b0;
      size      <= '0;
      sext      <= 1'b0;
      user_acc  <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr     <= addr_n;
        wb_data  <= sum;
        wb_en    <= wbe_n;
        size     <= size_n;
        sext     <= sext_n;
        user_acc <= 1'b1;
        illegal  <= bad;
      end
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_user_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> user_acc);
  assert_post_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (form != FORM_PREIMM)) |=> (addr == $past(base)));
  assert_pre_nowb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (form == FORM_PREIMM)) |=> !wb_en);
  assert_r15_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (form == FORM_POSTREG) && (rm_idx == 4'd15)) |=> illegal);
  assert_store_sext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_load) |=> !sext);
  assert_no_wb_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> !wb_en);
endmodule

// File: tb/unpriv_agu_bench.sv
module unpriv_agu_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  form;
  logic [2:0]  acc;
  logic        is_load;
  logic        up;
  logic [31:0] base;
  logic [31:0] rm_val;
  logic [3:0]  rm_idx;
  logic [11:0] imm;
  logic [2:0]  shift_kind;
  logic [5:0]  shift_amt;
  logic        carry_in;
  logic        out_valid;
  logic [31:0] addr;
  logic [31:0] wb_data;
  logic        wb_en;
  logic [1:0]  size;
  logic        sext;
  logic        user_acc;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  unpriv_agu u_unpriv_agu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form(form), .acc(acc),
    .is_load(is_load), .up(up), .base(base), .rm_val(rm_val), .rm_idx(rm_idx),
    .imm(imm), .shift_kind(shift_kind), .shift_amt(shift_amt), .carry_in(carry_in),
    .out_valid(out_valid), .addr(addr), .wb_data(wb_data), .wb_en(wb_en),
    .size(size), .sext(sext), .user_acc(user_acc), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]  f;
    logic [2:0]  a;
    logic        ld;
    logic        u;
    logic [31:0] b;
    logic [31:0] rm;
    logic [3:0]  ri;
    logic [11:0] im;
    logic [2:0]  sk;
    logic [5:0]  sa;
    logic        ci;
    logic [31:0] e_addr;
    logic [31:0] e_wb;
    logic        e_wbe;
    logic        e_ill;
    logic [1:0]  e_size;
    logic        e_sext;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd0,3'd0,1'b1,1'b1,32'h1000,32'h0,4'd0,12'h0FF,3'd0,6'd0,1'b0,32'h10FF,32'h10FF,1'b0,1'b0,2'd2,1'b0},
    '{2'd0,3'd0,1'b1,1'b1,32'h1000,32'h0,4'd0,12'h100,3'd0,6'd0,1'b0,32'h1100,32'h1100,1'b0,1'b1,2'd2,1'b0},
    '{2'd1,3'd0,1'b1,1'b1,32'h1000,32'h0,4'd0,12'hFFF,3'd0,6'd0,1'b0,32'h1000,32'h1FFF,1'b1,1'b0,2'd2,1'b0},
    '{2'd1,3'd1,1'b1,1'b0,32'h1000,32'h0,4'd0,12'h010,3'd0,6'd0,1'b0,32'h1000,32'h0FF0,1'b1,1'b0,2'd0,1'b0},
    '{2'd1,3'd4,1'b1,1'b0,32'h1000,32'h0,4'd0,12'h0FF,3'd0,6'd0,1'b0,32'h1000,32'h0F01,1'b1,1'b0,2'd1,1'b1},
    '{2'd1,3'd3,1'b0,1'b1,32'h1000,32'h0,4'd0,12'h100,3'd0,6'd0,1'b0,32'h1000,32'h1100,1'b0,1'b1,2'd1,1'b0},
    '{2'd2,3'd0,1'b1,1'b1,32'h1000,32'h10,4'd3,12'h0,3'd0,6'd4,1'b0,32'h1000,32'h1100,1'b1,1'b0,2'd2,1'b0},
    '{2'd2,3'd0,1'b1,1'b0,32'h1000,32'h80000000,4'd3,12'h0,3'd1,6'd32,1'b0,32'h1000,32'h1000,1'b1,1'b0,2'd2,1'b0},
    '{2'd2,3'd0,1'b1,1'b1,32'h1000,32'h80000000,4'd3,12'h0,3'd2,6'd32,1'b0,32'h1000,32'h0FFF,1'b1,1'b0,2'd2,1'b0},
    '{2'd2,3'd0,1'b1,1'b1,32'h1000,32'h11,4'd3,12'h0,3'd3,6'd4,1'b0,32'h1000,32'h10001001,1'b1,1'b0,2'd2,1'b0},
    '{2'd2,3'd0,1'b1,1'b1,32'h1000,32'h2,4'd3,12'h0,3'd4,6'd1,1'b1,32'h1000,32'h80001001,1'b1,1'b0,2'd2,1'b0},
    '{2'd2,3'd0,1'b1,1'b1,32'h1000,32'h4,4'd15,12'h0,3'd0,6'd0,1'b0,32'h1000,32'h1004,1'b0,1'b1,2'd2,1'b0},
    '{2'd2,3'd0,1'b1,1'b1,32'h1000,32'h4,4'd3,12'h0,3'd1,6'd0,1'b0,32'h1000,32'h1004,1'b0,1'b1,2'd2,1'b0},
    '{2'd2,3'd0,1'b1,1'b1,32'h1000,32'h4,4'd3,12'h0,3'd3,6'd32,1'b0,32'h1000,32'h1004,1'b0,1'b1,2'd2,1'b0},
    '{2'd2,3'd4,1'b1,1'b1,32'h1000,32'h4,4'd3,12'h0,3'd0,6'd1,1'b0,32'h1000,32'h1008,1'b0,1'b1,2'd1,1'b1},
    '{2'd2,3'd2,1'b1,1'b1,32'h1000,32'h4,4'd3,12'h0,3'd0,6'd0,1'b0,32'h1000,32'h1004,1'b1,1'b0,2'd0,1'b1},
    '{2'd1,3'd2,1'b0,1'b1,32'h1000,32'h0,4'd0,12'h004,3'd0,6'd0,1'b0,32'h1000,32'h1004,1'b0,1'b1,2'd0,1'b0},
    '{2'd2,3'd1,1'b1,1'b0,32'h1000,32'h1,4'd3,12'h0,3'd0,6'd31,1'b0,32'h1000,32'h80001000,1'b1,1'b0,2'd0,1'b0},
    '{2'd2,3'd0,1'b1,1'b1,32'h1000,32'h4,4'd3,12'h0,3'd0,6'd32,1'b0,32'h1000,32'h1000,1'b0,1'b1,2'd2,1'b0},
    '{2'd0,3'd0,1'b1,1'b0,32'h1000,32'h0,4'd0,12'h010,3'd0,6'd0,1'b0,32'h1010,32'h1010,1'b0,1'b0,2'd2,1'b0}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 19:             return "R3";
      1:                 return "R5";
      2, 3, 4:           return "R4";
      5:                 return "R5";
      6, 7, 8, 9, 10:    return "R6";
      11:                return "R9";
      12, 13, 18:        return "R7";
      14:                return "R8";
      15:                return "R10";
      16:                return "R11";
      default:           return "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid   = 1'b1;
    form       = v.f;
    acc        = v.a;
    is_load    = v.ld;
    up         = v.u;
    base       = v.b;
    rm_val     = v.rm;
    rm_idx     = v.ri;
    imm        = v.im;
    shift_kind = v.sk;
    shift_amt  = v.sa;
    carry_in   = v.ci;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; form = '0; acc = '0; is_load = 1'b0; up = 1'b0;
    base = '0; rm_val = '0; rm_idx = '0; imm = '0; shift_kind = '0; shift_amt = '0;
    carry_in = 1'b0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(!out_valid && !wb_en && !illegal && !user_acc && !sext, "R13", "flags in reset",
        {27'd0, out_valid, wb_en, illegal, user_acc, sext}, 32'd0);
    chk(addr == 32'd0 && wb_data == 32'd0 && size == 2'd0, "R13", "data in reset",
        addr | wb_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = tag_of(i);
      drive(VECS[i]);
      @(negedge clk);
      chk(out_valid == 1'b1, "R1", "out_valid", {31'd0, out_valid}, 32'd1);
      chk(user_acc == 1'b1, "R2", "user_acc", {31'd0, user_acc}, 32'd1);
      chk(addr == VECS[i].e_addr, t, $sformatf("addr vec %0d", i), addr, VECS[i].e_addr);
      chk(wb_data == VECS[i].e_wb, t, $sformatf("wb_data vec %0d", i), wb_data, VECS[i].e_wb);
      chk(wb_en == VECS[i].e_wbe, (VECS[i].e_ill ? "R12" : t), $sformatf("wb_en vec %0d", i),
          {31'd0, wb_en}, {31'd0, VECS[i].e_wbe});
      chk(illegal == VECS[i].e_ill, t, $sformatf("illegal vec %0d", i),
          {31'd0, illegal}, {31'd0, VECS[i].e_ill});
      chk(size == VECS[i].e_size, "R10", $sformatf("size vec %0d", i),
          {30'd0, size}, {30'd0, VECS[i].e_size});
      chk(sext == VECS[i].e_sext, "R10", $sformatf("sext vec %0d", i),
          {31'd0, sext}, {31'd0, VECS[i].e_sext});
    end

    // R1: idle cycle drops valid, held data stays from last request
    in_valid = 1'b0;
    base = 32'hDEAD0000;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "idle out_valid", {31'd0, out_valid}, 32'd0);
    chk(addr == 32'h1010, "R1", "idle addr hold", addr, 32'h1010);

    // R11: form 3 rejected
    drive(VECS[2]);
    form = 2'd3;
    @(negedge clk);
    chk(illegal == 1'b1, "R11", "form 3 illegal", {31'd0, illegal}, 32'd1);
    chk(wb_en == 1'b0, "R12", "form 3 no writeback", {31'd0, wb_en}, 32'd0);

    // R11: acc above 4 rejected
    drive(VECS[2]);
    acc = 3'd5;
    @(negedge clk);
    chk(illegal == 1'b1, "R11", "acc 5 illegal", {31'd0, illegal}, 32'd1);

    // R13: reset mid-run clears outputs
    drive(VECS[2]);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && wb_en == 1'b0 && user_acc == 1'b0, "R13", "mid reset",
        {29'd0, out_valid, wb_en, user_acc}, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule